// File: doc/BRIEF.md
# Sector Write-Protection Gate

This block holds one protection flag per flash sector. Before a program or erase request reaches the storage array, the block checks it against the flag of the sector it targets. Software changes the flags only while the chip's reset input carries the elevated programming voltage. It does this with write strobes whose three mode-select address bits choose between setting and clearing the flag of the addressed sector. A clear is accepted only when every sector is already protected. A refused clear leaves every flag unchanged and raises an error pulse.

While the elevated voltage is present and no flag-changing write is in progress, every request is allowed. This is the temporary unprotect mode. The stored flags are never touched in this mode, so the per-sector protection returns exactly as it was as soon as the voltage drops. A separate status port returns the flag of any sector. Out-of-range sector addresses are treated as non-existent sectors.

The request and status paths are combinational, so a denied request is gated in the same cycle it is presented. All pins are plain control and status signals with no handshake. A request is simply allowed or denied in the cycle it appears.

Top module: `sector_guard`

## Requirements
- R1: With `hv_rst` low, a program or erase request to a protected sector gives `op_allow`=0. A request to an unprotected, in-range sector gives `op_allow`=1 in the same cycle. With no request, `op_allow` is 0.
- R2: A protect write (`wr_stb`=1, `hv_rst`=1, `wr_mode_bits`={bit6,bit1,bit0}=3'b010) sets the flag of `wr_sector`. The flag is visible from the next cycle.
- R3: An unprotect write (`wr_mode_bits`=3'b110, `wr_stb`=1, `hv_rst`=1) made while all sectors are protected clears the flag of `wr_sector` and raises no error.
- R4: An unprotect write made while any sector is unprotected changes no flag and drives `unprot_err` high for exactly the following cycle. `unprot_err` is low otherwise.
- R5: While `hv_rst`=1 and `wr_stb`=0, every request to an in-range sector is allowed, whatever its flag.
- R6: When `hv_rst` falls, each sector's protection is the same as it was before the voltage was applied, apart from explicit protect and unprotect writes.
- R7: After synchronous reset (`rst`=1), all sectors read unprotected and `unprot_err` is 0.
- R8: `st_prot` equals the current flag of `st_sector`, combinationally.
- R9: A write strobe with `hv_rst`=0, or with a mode pattern other than 3'b010 or 3'b110, changes no flag and raises no error.
- R10: A sector address at or above `NUM_SECTORS` is never allowed and reads as unprotected. A protect or unprotect write to it changes no flag. A refused unprotect still flags an error.
- R11: In a cycle where `hv_rst`=1 and `wr_stb`=1, requests are gated by the stored flags exactly as with `hv_rst` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hv_rst | input | 1 | Elevated programming voltage present on the reset pin |
| wr_stb | input | 1 | Write cycle strobe |
| wr_sector | input | SEC_AW | Sector address of the write cycle |
| wr_mode_bits | input | 3 | Address bits {6,1,0} of the write cycle |
| pgm_req | input | 1 | Program request |
| ers_req | input | 1 | Erase request |
| op_sector | input | SEC_AW | Sector addressed by the program or erase request |
| st_sector | input | SEC_AW | Sector whose protection is queried |
| op_allow | output | 1 | Request may proceed to the array |
| st_prot | output | 1 | Protection flag of `st_sector` |
| unprot_err | output | 1 | Pulse: an unprotect write was refused |

## Verification
A corrupted flag shows up in the cycle after it is written. It appears on `st_prot` when that sector is queried, and on `op_allow` for any request to that sector with the voltage low. The bench queries sectors every cycle, so such an error is seen within one clock. A wrong all-protected decision shows up as a spurious or missing `unprot_err` pulse one cycle after the unprotect write, followed by a flag that differs on the status port. A temporary mode that leaked into the stored flags would surface as a protection mismatch in the first cycle after `hv_rst` falls.

// File: rtl/sp_pkg.sv
package sp_pkg;

  typedef enum logic [1:0] {
    WOP_NONE   = 2'd0,
    WOP_PROT   = 2'd1,
    WOP_UNPROT = 2'd2
  } wop_e;

  typedef struct packed {
    logic        hit;
    logic [15:0] idx;
  } sec_ref_t;

  // Mode-bit patterns, ordered {bit6, bit1, bit0}
  localparam logic [2:0] MODE_PROT   = 3'b010;
  localparam logic [2:0] MODE_UNPROT = 3'b110;

  // Sector address to flag index; miss for non-existent sectors
  function automatic sec_ref_t sec_lookup(input logic [15:0] addr,
                                          input int unsigned nsec);
    sec_ref_t r;
    if (32'(addr) < nsec) begin
      r.hit = 1'b1;
      r.idx = addr;
    end else begin
      r.hit = 1'b0;
      r.idx = '0;
    end
    return r;
  endfunction

endpackage

// File: rtl/sp_sec_map.sv
module sp_sec_map #(
  parameter int NUM_SECTORS = 35,
  parameter int SEC_AW      = 6,
  parameter int IDX_W       = 6
) (
  input  logic [SEC_AW-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  sp_pkg::sec_ref_t r;

  always_comb begin
    r   = sp_pkg::sec_lookup(16'(addr), NUM_SECTORS);
    hit = r.hit;
    idx = IDX_W'(r.idx);
  end
endmodule

// File: rtl/sp_wr_decode.sv
module sp_wr_decode (
  input  logic         hv,
  input  logic         wr_stb,
  input  logic [2:0]   mode_bits,
  output sp_pkg::wop_e wop
);
  always_comb begin
    wop = sp_pkg::WOP_NONE;
    if (hv && wr_stb) begin
      if (mode_bits == sp_pkg::MODE_PROT)        wop = sp_pkg::WOP_PROT;
      else if (mode_bits == sp_pkg::MODE_UNPROT) wop = sp_pkg::WOP_UNPROT;
    end
  end
endmodule

// File: rtl/sp_prot_store.sv
module sp_prot_store #(
  parameter int NUM_SECTORS = 35,
  parameter int IDX_W       = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  sp_pkg::wop_e           wop,
  input  logic                   w_hit,
  input  logic [IDX_W-1:0]       w_idx,
  output logic [NUM_SECTORS-1:0] prot_q,
  output logic                   all_prot,
  output logic                   err_q
);
  assign all_prot = &prot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (wop)
        sp_pkg::WOP_PROT: begin
          if (w_hit) prot_q[w_idx] <= 1'b1;
        end
        sp_pkg::WOP_UNPROT: begin
          if (!all_prot)  err_q          <= 1'b1;
          else if (w_hit) prot_q[w_idx] <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  a_r2_protect_sets: assert property (@(posedge clk) disable iff (rst)
    (wop == sp_pkg::WOP_PROT && w_hit) |=> prot_q[$past(w_idx)]);

  a_r3_unprotect_clears: assert property (@(posedge clk) disable iff (rst)
    (wop == sp_pkg::WOP_UNPROT && all_prot && w_hit) |=> (!prot_q[$past(w_idx)] && !err_q));

  a_r4_refuse_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    (wop == sp_pkg::WOP_UNPROT && !all_prot) |=> (err_q && $stable(prot_q)));

  a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (wop == sp_pkg::WOP_NONE) |=> ($stable(prot_q) && !err_q));

  a_r7_reset_clear: assert property (@(posedge clk)
    rst |=> (prot_q == '0 && !err_q));
endmodule

// File: rtl/sp_access_gate.sv
module sp_access_gate (
  input  logic req,
  input  logic hit,
  input  logic flag,
  input  logic hv,
  input  logic wr_stb,
  output logic allow
);
  logic temp_lift;

  // Temporary unprotect holds only outside a flag-changing write cycle
  assign temp_lift = hv && !wr_stb;
  assign allow     = req && hit && (!flag || temp_lift);
endmodule

// File: rtl/sector_guard.sv
module sector_guard #(
  parameter int NUM_SECTORS = 35,
  parameter int SEC_AW      = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hv_rst,
  input  logic              wr_stb,
  input  logic [SEC_AW-1:0] wr_sector,
  input  logic [2:0]        wr_mode_bits,
  input  logic              pgm_req,
  input  logic              ers_req,
  input  logic [SEC_AW-1:0] op_sector,
  input  logic [SEC_AW-1:0] st_sector,
  output logic              op_allow,
  output logic              st_prot,
  output logic              unprot_err
);
  localparam int IDX_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1;

  sp_pkg::wop_e           wop;
  logic                   w_hit, o_hit, s_hit, all_prot;
  logic [IDX_W-1:0]       w_idx, o_idx, s_idx;
  logic [NUM_SECTORS-1:0] prot_vec;
  logic                   op_req;

  assign op_req = pgm_req || ers_req;

  sp_wr_decode u_dec (
    .hv(hv_rst), .wr_stb(wr_stb), .mode_bits(wr_mode_bits), .wop(wop)
  );

  sp_sec_map #(.NUM_SECTORS(NUM_SECTORS), .SEC_AW(SEC_AW), .IDX_W(IDX_W)) u_map_wr (
    .addr(wr_sector), .hit(w_hit), .idx(w_idx)
  );
  sp_sec_map #(.NUM_SECTORS(NUM_SECTORS), .SEC_AW(SEC_AW), .IDX_W(IDX_W)) u_map_op (
    .addr(op_sector), .hit(o_hit), .idx(o_idx)
  );
  sp_sec_map #(.NUM_SECTORS(NUM_SECTORS), .SEC_AW(SEC_AW), .IDX_W(IDX_W)) u_map_st (
    .addr(st_sector), .hit(s_hit), .idx(s_idx)
  );

  sp_prot_store #(.NUM_SECTORS(NUM_SECTORS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .wop(wop), .w_hit(w_hit), .w_idx(w_idx),
    .prot_q(prot_vec), .all_prot(all_prot), .err_q(unprot_err)
  );

  sp_access_gate u_gate (
    .req(op_req), .hit(o_hit), .flag(prot_vec[o_idx]),
    .hv(hv_rst), .wr_stb(wr_stb), .allow(op_allow)
  );

  assign st_prot = s_hit && prot_vec[s_idx];

  a_r1_protected_denied: assert property (@(posedge clk) disable iff (rst)
    (!hv_rst && o_hit && prot_vec[o_idx]) |-> !op_allow);

  a_r5_temp_lift: assert property (@(posedge clk) disable iff (rst)
    (hv_rst && !wr_stb && op_req && o_hit) |-> op_allow);

  a_r10_range_denied: assert property (@(posedge clk) disable iff (rst)
    (!o_hit) |-> !op_allow);

  a_r11_write_cycle_gated: assert property (@(posedge clk) disable iff (rst)
    (hv_rst && wr_stb && o_hit && prot_vec[o_idx]) |-> !op_allow);
endmodule

// File: tb/test_sector_guard.sv
`timescale 1ns/1ps
module test_sector_guard;
  localparam int N  = 35;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst, hv_rst, wr_stb, pgm_req, ers_req;
  logic [AW-1:0] wr_sector, op_sector, st_sector;
  logic [2:0] wr_mode_bits;
  logic op_allow, st_prot, unprot_err;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  string tag  = "R7";

  logic [63:0] ref_prot = '0;
  logic        ref_err  = 1'b0;

  always #2 clk = ~clk;

  sector_guard #(.NUM_SECTORS(N), .SEC_AW(AW)) i_sector_guard (
    .clk(clk), .rst(rst), .hv_rst(hv_rst), .wr_stb(wr_stb),
    .wr_sector(wr_sector), .wr_mode_bits(wr_mode_bits),
    .pgm_req(pgm_req), .ers_req(ers_req), .op_sector(op_sector),
    .st_sector(st_sector), .op_allow(op_allow), .st_prot(st_prot),
    .unprot_err(unprot_err)
  );

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(string t, string what, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", t, what, act, exp);
    end
  endtask

  task automatic drive(logic hv, logic stb, int ws, logic [2:0] m,
                       logic pg, logic er, int os, int ss);
    hv_rst = hv; wr_stb = stb; wr_sector = AW'(ws); wr_mode_bits = m;
    pgm_req = pg; ers_req = er; op_sector = AW'(os); st_sector = AW'(ss);
  endtask

  // Advance one clock, update the reference at the edge, compare at negedge
  task automatic step();
    logic all_p;
    logic e_allow, e_st;
    @(posedge clk);
    @(negedge clk);
    all_p = 1'b1;
    for (int i = 0; i < N; i++) if (!ref_prot[i]) all_p = 1'b0;
    if (rst) begin
      ref_prot = '0; ref_err = 1'b0;
    end else begin
      ref_err = 1'b0;
      if (hv_rst && wr_stb && wr_mode_bits == 3'b010) begin
        if (int'(wr_sector) < N) ref_prot[wr_sector] = 1'b1;
      end else if (hv_rst && wr_stb && wr_mode_bits == 3'b110) begin
        if (!all_p) ref_err = 1'b1;
        else if (int'(wr_sector) < N) ref_prot[wr_sector] = 1'b0;
      end
    end
    e_allow = (pgm_req || ers_req) && int'(op_sector) < N &&
              (!ref_prot[op_sector] || (hv_rst && !wr_stb));
    e_st = int'(st_sector) < N && ref_prot[st_sector];
    chk(tag, "op_allow", op_allow, e_allow);
    chk(tag == "R7" ? "R7" : "R8", "st_prot", st_prot, e_st);
    chk(tag == "R7" ? "R7" : "R4", "unprot_err", unprot_err, ref_err);
  endtask

  initial begin
    rst = 1'b1;
    drive(0, 0, 0, 3'b000, 0, 0, 0, 0);
    // R7: reset state, every sector unprotected
    tag = "R7";
    step(); step();
    for (int s = 0; s < N; s++) begin
      drive(0, 0, 0, 3'b000, 1, 0, s, s);
      step();
    end
    rst = 1'b0;
    // R1: unprotected sector allowed, idle gives no allow
    tag = "R1";
    drive(0, 0, 0, 3'b000, 1, 0, 3, 3); step();
    drive(0, 0, 0, 3'b000, 0, 0, 3, 3); step();
    // R9: write without voltage, or with a foreign mode pattern, ignored
    tag = "R9";
    drive(0, 1, 3, 3'b010, 0, 0, 3, 3); step();
    drive(0, 0, 0, 3'b000, 1, 0, 3, 3); step();
    drive(1, 1, 3, 3'b011, 0, 0, 3, 3); step();
    drive(1, 1, 3, 3'b100, 0, 0, 3, 3); step();
    drive(0, 0, 0, 3'b000, 0, 1, 3, 3); step();
    // R2: protect sectors 3, 10, 34; R11: requests during those cycles gated
    tag = "R2";
    drive(1, 1, 3, 3'b010, 0, 0, 0, 3); step();
    tag = "R11";
    drive(1, 1, 10, 3'b010, 1, 0, 3, 3); step();
    drive(1, 1, 34, 3'b010, 0, 1, 10, 10); step();
    // R1: protected sectors denied for program and erase
    tag = "R1";
    drive(0, 0, 0, 3'b000, 1, 0, 3, 34); step();
    drive(0, 0, 0, 3'b000, 0, 1, 10, 10); step();
    drive(0, 0, 0, 3'b000, 1, 1, 4, 4); step();
    // R10: out-of-range addresses
    tag = "R10";
    drive(1, 1, 50, 3'b010, 1, 0, 40, 50); step();
    drive(0, 0, 0, 3'b000, 1, 1, 63, 35); step();
    // R4: unprotect refused while sectors remain unprotected
    tag = "R4";
    drive(1, 1, 3, 3'b110, 0, 0, 3, 3); step();
    drive(0, 0, 0, 3'b000, 1, 0, 3, 3); step();
    // R5: temporary unprotect lifts everything
    tag = "R5";
    drive(1, 0, 0, 3'b000, 1, 0, 3, 3); step();
    drive(1, 0, 0, 3'b000, 0, 1, 10, 34); step();
    drive(1, 0, 0, 3'b000, 1, 0, 34, 10); step();
    // R6: voltage removed, previous protection back
    tag = "R6";
    for (int s = 0; s < N; s++) begin
      drive(0, 0, 0, 3'b000, 1, 0, s, s);
      step();
    end
    // R3: protect all, then unprotect 10 succeeds; second unprotect refused
    tag = "R2";
    for (int s = 0; s < N; s++) begin
      drive(1, 1, s, 3'b010, 0, 0, 0, s);
      step();
    end
    tag = "R3";
    drive(1, 1, 10, 3'b110, 0, 0, 10, 10); step();
    drive(0, 0, 0, 3'b000, 1, 0, 10, 10); step();
    drive(1, 1, 20, 3'b110, 0, 0, 20, 20); step();
    drive(0, 0, 0, 3'b000, 1, 0, 20, 20); step();
    // R8: mixed traffic with status sweep
    tag = "R8";
    for (int k = 0; k < 600; k++) begin
      logic [2:0] m;
      m = ($urandom % 3 == 0) ? 3'b110 : (($urandom % 2 == 0) ? 3'b010 : 3'($urandom));
      drive($urandom % 3 == 0, $urandom % 2 == 0, $urandom % 40, m,
            $urandom % 2 == 0, $urandom % 2 == 0, $urandom % 40, $urandom % 40);
      step();
    end
    // R7: reset again clears everything
    tag = "R7";
    rst = 1'b1;
    drive(0, 0, 0, 3'b000, 1, 0, 3, 3); step();
    rst = 1'b0;
    drive(0, 0, 0, 3'b000, 1, 0, 34, 34); step();
    summary();
    $finish;
  end
endmodule